// File: doc/BRIEF.md
# Bidirectional I/O Port Controller with Latch Readback

This block controls one general-purpose I/O port. Software reaches three registers over a small register bus: an output latch, a direction register with one bit per pin, and a pull-up register whose bits each cover a group of pins. The block drives, for every pin, an output value, an output enable and a pull-up enable. The pad cell that combines them is outside the block.

The pin levels come in through a two-flop synchroniser. A read of the data address returns a mix, chosen bit by bit from the direction register. Bits set as outputs return what was last written to the latch. Bits set as inputs return the synchronised pin level. A write to the data address always lands in the latch, whatever the direction. A value parked in the latch while a pin is an input appears on that pin on the cycle its direction bit turns to output.

Each pin's pull-up follows its group bit. It is forced off while that pin is an output, so a driven pin never has its pull-up enabled. Reads are registered: bus_rdata shows the register selected by bus_addr one clock after the address is presented.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A direction bit of 1 makes its pin an output and a 0 makes it an input. pin_oe equals the direction register (address 1) from the clock edge that writes it.
- R2: A read of the data register (address 0) returns the latch value for every bit whose direction bit is 1.
- R3: A read of the data register returns the synchronised pin level for every bit whose direction bit is 0.
- R4: A write to address 0 updates the latch for all bits, whatever the direction, and pin_out always presents the latch. A bit written while it is an input drives that value as soon as its direction bit becomes 1.
- R5: The pull-up register (address 2) holds PU_GRP group bits. With the default map, bit 0 covers pin 0, bit 1 covers pin 1, bit 2 covers pins 2 and 3, and bit 3 covers pins 4 to 7. For an input pin, pin_pu equals the bit of its group.
- R6: pin_pu is 0 for every pin whose direction bit is 1. It changes on the same clock edge as pin_oe, so pin_pu & pin_oe is always 0.
- R7: A synchronous active-high reset clears the latch, the direction register (all inputs), the pull-up register and the synchroniser. pin_out, pin_oe, pin_pu and bus_rdata then read 0.
- R8: A pin change presented before clock edge k shows in the readback registered at edge k+2. The readback registered at edge k+1 still shows the old level.
- R9: Address 3 reads as 0 and a write to it has no effect. A read of address 2 returns the group bits in its low PU_GRP bits and 0 above them. bus_rdata is registered one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 unused |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Registered read data of the register selected on the previous cycle |
| pin_in | input | PORT_W | Asynchronous pin levels from the pads |
| pin_out | output | PORT_W | Output value per pin (the latch) |
| pin_oe | output | PORT_W | Output enable per pin (the direction register) |
| pin_pu | output | PORT_W | Pull-up enable per pin, gated off for outputs |

## Verification
The bench builds the block with its defaults: eight pins, four pull-up groups and the uneven 1-1-2-4 group map. This map lets a single group bit enable one pin, a pair or a nibble, and the tests cover each case. Using the full port width with mixed direction patterns puts latch bits and pin bits side by side in one readback. The default two-flop synchroniser allows an exact latency check on the edge before the pin change becomes visible and on the edge where it does.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int PU_GRP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PU_GRP-1:0] pu_q,
  output logic [PORT_W-1:0] dir_d,
  output logic [PU_GRP-1:0] pu_d
);
  logic [PORT_W-1:0] latch_d;

  // Next-state values; exported so downstream registers update on the same edge.
  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    pu_d    = pu_q;
    if (we) begin
      unique case (sel)
        REG_DATA: latch_d = wdata;
        REG_DIR:  dir_d   = wdata;
        REG_PULL: pu_d    = wdata[PU_GRP-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pu_q    <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      pu_q    <= pu_d;
    end
  end
endmodule

// File: rtl/gpio_pullup_map.sv
module gpio_pullup_map #(
  parameter int                        PORT_W    = 8,
  parameter int                        PU_GRP    = 4,
  parameter int                        GRP_IDX_W = 2,
  parameter logic [PORT_W*GRP_IDX_W-1:0] PU_MAP  = 16'b11_11_11_11_10_10_01_00
) (
  input  logic [PU_GRP-1:0] grp_en,
  input  logic [PORT_W-1:0] dir,
  output logic [PORT_W-1:0] pu_en
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam logic [GRP_IDX_W-1:0] GRP = PU_MAP[i*GRP_IDX_W +: GRP_IDX_W];
    assign pu_en[i] = grp_en[GRP] & ~dir[i];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int                        PORT_W    = 8,
  parameter int                        PU_GRP    = 4,
  parameter int                        GRP_IDX_W = 2,
  parameter logic [PORT_W*GRP_IDX_W-1:0] PU_MAP  = 16'b11_11_11_11_10_10_01_00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu
);
  logic [PORT_W-1:0] latch_q, dir_q, dir_d, pin_sync, pu_next, rd_mux;
  logic [PU_GRP-1:0] pu_q, pu_d;
  logic [PORT_W-1:0] rdata_q, pu_out_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(bus_addr);

  gpio_sync #(.WIDTH(PORT_W)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regs #(.PORT_W(PORT_W), .PU_GRP(PU_GRP)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pu_q(pu_q),
    .dir_d(dir_d), .pu_d(pu_d)
  );

  // Computed from next-state so pull-ups drop on the edge that sets an output.
  gpio_pullup_map #(
    .PORT_W(PORT_W), .PU_GRP(PU_GRP), .GRP_IDX_W(GRP_IDX_W), .PU_MAP(PU_MAP)
  ) u_pumap (
    .grp_en(pu_d), .dir(dir_d), .pu_en(pu_next)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_DATA: rd_mux = (latch_q & dir_q) | (pin_sync & ~dir_q);
      REG_DIR:  rd_mux = dir_q;
      REG_PULL: rd_mux[PU_GRP-1:0] = pu_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      pu_out_q <= '0;
    end else begin
      rdata_q  <= rd_mux;
      pu_out_q <= pu_next;
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = latch_q;
  assign pin_oe    = dir_q;
  assign pin_pu    = pu_out_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_we,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_pu
);
  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1) |=> (pin_oe == $past(bus_wdata)));

  // R4
  latch_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata)));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == 2'd0) |=> $stable(pin_out));

  // R6
  pu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

  // R9
  unused_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd3) |=> (bus_rdata == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  // {dir, latch, pin, expected data readback}
  localparam logic [31:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h3C, 8'hA5},
    {8'h00, 8'hA5, 8'h3C, 8'h3C},
    {8'hF0, 8'h12, 8'h9E, 8'h1E},
    {8'h0F, 8'hC3, 8'h5A, 8'h53},
    {8'hAA, 8'hFF, 8'h00, 8'hAA},
    {8'h55, 8'h00, 8'hFF, 8'hAA}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R7 reset state
    chk("R7 oe", pin_oe, 8'h00);
    chk("R7 pu", pin_pu, 8'h00);
    chk("R7 out", pin_out, 8'h00);
    rd(2'd1, v); chk("R7 dir read", v, 8'h00);
    rd(2'd2, v); chk("R7 pull read", v, 8'h00);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, VEC[i][31:24]);
      wr(2'd0, VEC[i][23:16]);
      pin_in = VEC[i][15:8];
      idle(4);
      rd(2'd0, v);
      chk("R2/R3 readback", v, VEC[i][7:0]);
      chk("R1 oe", pin_oe, VEC[i][31:24]);
      chk("R4 out", pin_out, VEC[i][23:16]);
    end

    // R4 latch written while input, then switched to output
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h6C);
    pin_in = 8'h00;
    chk("R4 undriven oe", pin_oe, 8'h00);
    chk("R4 latch parked", pin_out, 8'h6C);
    wr(2'd1, 8'hFF);
    chk("R4 driven oe", pin_oe, 8'hFF);
    chk("R4 driven out", pin_out, 8'h6C);
    rd(2'd0, v); chk("R4 readback after switch", v, 8'h6C);

    // R5 group map
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0F); chk("R5 all groups", pin_pu, 8'hFF);
    wr(2'd2, 8'h04); chk("R5 pair group", pin_pu, 8'h0C);
    wr(2'd2, 8'h08); chk("R5 nibble group", pin_pu, 8'hF0);
    wr(2'd2, 8'h01); chk("R5 single group", pin_pu, 8'h01);

    // R6 gating by direction, same edge as oe
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'hF0);
    chk("R6 gated low nibble", pin_pu, 8'h0F);
    chk("R6 oe same edge", pin_oe, 8'hF0);
    wr(2'd1, 8'h20); chk("R6 one pin out", pin_pu, 8'hDF);

    // R9 map and ignored address
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R9 pull read width", v, 8'h0F);
    wr(2'd0, 8'h3A);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R9 unused reads zero", v, 8'h00);
    rd(2'd1, v); chk("R9 dir untouched", v, 8'h20);
    chk("R9 out untouched", pin_out, 8'h3A);
    chk("R9 pu untouched", pin_pu, 8'hDF);

    // R8 synchroniser latency
    wr(2'd1, 8'h00);
    pin_in = 8'h00;
    idle(4);
    @(negedge clk);
    pin_in = 8'h81; bus_addr = 2'd0;
    @(negedge clk);
    @(negedge clk); chk("R8 old level at k+1", bus_rdata, 8'h00);
    @(negedge clk); chk("R8 new level at k+2", bus_rdata, 8'h81);

    // R7 reset mid-run
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'h0F);
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    chk("R7 mid oe", pin_oe, 8'h00);
    chk("R7 mid pu", pin_pu, 8'h00);
    chk("R7 mid out", pin_out, 8'h00);
    rd(2'd2, v); chk("R7 mid pull", v, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule